// File: doc/BRIEF.md
# Serial Interconnect Endpoint Configuration Register File

This block holds the configuration register space of a serial packet-interconnect endpoint, as seen by maintenance read and write transactions arriving from the link. A maintenance handler presents one request per cycle on a word-aligned byte-address port. For each request it gives a write flag, 32-bit write data and a 4-bit byte enable. Read data comes back on a response strobe exactly one cycle later. The block always accepts: `req_ready` is held high, and there is no back-pressure on either side. The response strobe cannot be stalled, so the handler must capture the read data in the cycle it appears.

The space contains:
- read-only capability words that come from elaboration parameters;
- a writable base device ID and a component tag;
- the link and response timeout words;
- a port general control word that carries the master enable bit;
- an implementation-defined word whose low half is the destination ID for outgoing maintenance requests.

The host lock word follows a write-once rule. It resets to all-ones in its low 16 bits. The first write of any other value claims it. While it is claimed, only a write of the owner's own value frees it.

Top module: `rio_cfg_regs`

## Requirements
- R1: After reset, the word at 0x68 reads 0x0000FFFF, the word at 0x60 reads the BASE_ID parameter (default 0x00000001), `master_en` is 0 and `maint_dest_id` is 0.
- R2: `req_ready` is always 1. A read request gives `rsp_valid` = 1 with its data on the next cycle. A write request gives no response (`rsp_valid` = 0 on the next cycle).
- R3: The word at 0x10 reads {bridge, memory, processor, 1'b0 (switch), 23'b0, 16-bit-ID support, 1'b1 (extended features), 3'b001}, with bits 31..29 and bit 4 taken from parameters. Its default value is 0xE0000019, and writes to it are ignored.
- R4: An offset that holds no register reads 0 (for example 0x70 or 0x200), and a write to it has no effect.
- R5: On a writable word, only the bytes whose `req_be` bit is set are updated. `req_be[k]` covers bits 8k+7..8k. The component tag at 0x6C and the base ID at 0x60 are fully writable.
- R6: While the lock word holds 0xFFFF, a write of any other low-16 value stores it. This claims the lock.
- R7: While claimed, a write of a low-16 value that differs from the stored one is ignored. This includes 0xFFFF.
- R8: While claimed, a write equal to the stored value sets the word back to 0xFFFF, which frees it.
- R9: Writing 0xFFFF to a free lock word leaves it free at 0xFFFF.
- R10: A lock write takes effect only when `req_be[1:0]` is 2'b11. Bits 31..16 of 0x68 always read 0.
- R11: Bits 31..29 of the word at 0x13C are writable, reset to 0, and all other bits read 0. Bit 30 drives `master_en`.
- R12: The low 16 bits of the word at 0x10100 are writable and drive `maint_dest_id`. Its upper 16 bits read 0.
- R13: The timeout words at 0x120 and 0x124 have bits 31..8 writable with a reset value of 0xFFFFFF. Bits 7..0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Always 1, so a request is never refused |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 24 | Byte address in configuration space; bits 1..0 ignored |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| master_en | output | 1 | Master enable; allows the endpoint to issue requests |
| maint_dest_id | output | 16 | Destination ID for outgoing maintenance requests |

## Verification
The bench works through the lock word's whole life cycle. A design that locked on 0xFFFF would strand the register. A design that accepted a second owner would let two hosts both believe they hold the lock. A design that freed the lock on any write would erase the enumeration ownership. Partial byte-enable writes aimed at the lock word and at ordinary words catch a design that merges bytes wrongly or claims the lock on a half-written ID. Writes to read-only and empty offsets, followed by reads of the same offsets, expose address aliasing. Checks on `master_en` and `maint_dest_id` catch a design that writes the wrong bit or lane.

// File: rtl/rio_cfg_pkg.sv
package rio_cfg_pkg;
  localparam int unsigned CFG_AW = 24;
  localparam int unsigned CFG_DW = 32;
  localparam int unsigned CFG_BW = CFG_DW / 8;

  localparam logic [CFG_AW-1:0] OFF_DEVID   = 24'h000000;
  localparam logic [CFG_AW-1:0] OFF_DEVINFO = 24'h000004;
  localparam logic [CFG_AW-1:0] OFF_FEAT    = 24'h000010;
  localparam logic [CFG_AW-1:0] OFF_BASEID  = 24'h000060;
  localparam logic [CFG_AW-1:0] OFF_LOCK    = 24'h000068;
  localparam logic [CFG_AW-1:0] OFF_CTAG    = 24'h00006C;
  localparam logic [CFG_AW-1:0] OFF_PHDR    = 24'h000100;
  localparam logic [CFG_AW-1:0] OFF_LTO     = 24'h000120;
  localparam logic [CFG_AW-1:0] OFF_RTO     = 24'h000124;
  localparam logic [CFG_AW-1:0] OFF_GCTL    = 24'h00013C;
  localparam logic [CFG_AW-1:0] OFF_MREQ    = 24'h010100;

  localparam logic [15:0] LOCK_FREE = 16'hFFFF;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DEVID, SEL_DEVINFO, SEL_FEAT, SEL_BASEID, SEL_LOCK,
    SEL_CTAG, SEL_PHDR, SEL_LTO, SEL_RTO, SEL_GCTL, SEL_MREQ
  } reg_sel_e;
endpackage

// File: rtl/rio_cfg_decode.sv
module rio_cfg_decode
  import rio_cfg_pkg::*;
(
  input  logic [CFG_AW-1:0] addr,
  output reg_sel_e          sel
);
  logic [CFG_AW-3:0] waddr;
  assign waddr = addr[CFG_AW-1:2];

  always_comb begin
    sel = SEL_NONE;
    unique case (waddr)
      OFF_DEVID[CFG_AW-1:2]:   sel = SEL_DEVID;
      OFF_DEVINFO[CFG_AW-1:2]: sel = SEL_DEVINFO;
      OFF_FEAT[CFG_AW-1:2]:    sel = SEL_FEAT;
      OFF_BASEID[CFG_AW-1:2]:  sel = SEL_BASEID;
      OFF_LOCK[CFG_AW-1:2]:    sel = SEL_LOCK;
      OFF_CTAG[CFG_AW-1:2]:    sel = SEL_CTAG;
      OFF_PHDR[CFG_AW-1:2]:    sel = SEL_PHDR;
      OFF_LTO[CFG_AW-1:2]:     sel = SEL_LTO;
      OFF_RTO[CFG_AW-1:2]:     sel = SEL_RTO;
      OFF_GCTL[CFG_AW-1:2]:    sel = SEL_GCTL;
      OFF_MREQ[CFG_AW-1:2]:    sel = SEL_MREQ;
      default:                 sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/rio_cfg_wreg.sv
module rio_cfg_wreg
  import rio_cfg_pkg::*;
#(
  parameter logic [CFG_DW-1:0] RST_VAL = '0,
  parameter logic [CFG_DW-1:0] WR_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CFG_BW-1:0] be,
  input  logic [CFG_DW-1:0] wdata,
  output logic [CFG_DW-1:0] q
);
  localparam logic [CFG_DW-1:0] RST_MASKED = RST_VAL & WR_MASK;

  for (genvar b = 0; b < CFG_BW; b++) begin : g_byte
    localparam logic [7:0] BMASK = WR_MASK[8*b +: 8];
    localparam logic [7:0] BRST  = RST_MASKED[8*b +: 8];
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        byte_q <= BRST;
      else if (we && be[b])
        byte_q <= wdata[8*b +: 8] & BMASK;
    end
    assign q[8*b +: 8] = byte_q;
  end
endmodule

// File: rtl/rio_cfg_lock.sv
module rio_cfg_lock
  import rio_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [1:0]  be,
  input  logic [15:0] wdata,
  output logic [15:0] val
);
  logic full_wr;
  logic is_free;
  assign full_wr = we && (be == 2'b11);
  assign is_free = (val == LOCK_FREE);

  always_ff @(posedge clk) begin
    if (!rst_n)
      val <= LOCK_FREE;
    else if (full_wr) begin
      if (is_free)
        val <= wdata;
      else if (wdata == val)
        val <= LOCK_FREE;
    end
  end
endmodule

// File: rtl/rio_cfg_regs.sv
module rio_cfg_regs
  import rio_cfg_pkg::*;
#(
  parameter logic [31:0] DEV_ID_CAR   = 32'h1A2B_0C3D,
  parameter logic [31:0] DEV_INFO_CAR = 32'h0000_0001,
  parameter logic [31:0] BASE_ID      = 32'h0000_0001,
  parameter logic [31:0] PORT_HDR     = 32'h0000_0001,
  parameter bit          HAS_BRIDGE   = 1'b1,
  parameter bit          HAS_MEMORY   = 1'b1,
  parameter bit          HAS_PROC     = 1'b1,
  parameter bit          DEVID_16     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [CFG_AW-1:0] req_addr,
  input  logic [CFG_BW-1:0] req_be,
  input  logic [CFG_DW-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [CFG_DW-1:0] rsp_rdata,
  output logic              master_en,
  output logic [15:0]       maint_dest_id
);
  localparam logic [31:0] FEAT_VAL =
    {HAS_BRIDGE, HAS_MEMORY, HAS_PROC, 1'b0, 23'b0, DEVID_16, 1'b1, 3'b001};
  localparam logic [31:0] MASK_FULL = 32'hFFFF_FFFF;
  localparam logic [31:0] MASK_TO   = 32'hFFFF_FF00;
  localparam logic [31:0] MASK_GCTL = 32'hE000_0000;
  localparam logic [31:0] MASK_MREQ = 32'h0000_FFFF;
  localparam int unsigned MST_BIT   = 30;

  reg_sel_e    sel;
  logic        wr;
  logic [31:0] baseid_q, ctag_q, lto_q, rto_q, gctl_q, mreq_q;
  logic [15:0] lock_val;
  logic [31:0] rd_mux;

  assign req_ready = 1'b1;
  assign wr = req_valid && req_write;

  rio_cfg_decode u_dec (.addr(req_addr), .sel(sel));

  rio_cfg_wreg #(.RST_VAL(BASE_ID), .WR_MASK(MASK_FULL)) u_baseid (
    .clk(clk), .rst_n(rst_n), .we(wr && sel == SEL_BASEID), .be(req_be),
    .wdata(req_wdata), .q(baseid_q));
  rio_cfg_wreg #(.RST_VAL(32'h0), .WR_MASK(MASK_FULL)) u_ctag (
    .clk(clk), .rst_n(rst_n), .we(wr && sel == SEL_CTAG), .be(req_be),
    .wdata(req_wdata), .q(ctag_q));
  rio_cfg_wreg #(.RST_VAL(MASK_TO), .WR_MASK(MASK_TO)) u_lto (
    .clk(clk), .rst_n(rst_n), .we(wr && sel == SEL_LTO), .be(req_be),
    .wdata(req_wdata), .q(lto_q));
  rio_cfg_wreg #(.RST_VAL(MASK_TO), .WR_MASK(MASK_TO)) u_rto (
    .clk(clk), .rst_n(rst_n), .we(wr && sel == SEL_RTO), .be(req_be),
    .wdata(req_wdata), .q(rto_q));
  rio_cfg_wreg #(.RST_VAL(32'h0), .WR_MASK(MASK_GCTL)) u_gctl (
    .clk(clk), .rst_n(rst_n), .we(wr && sel == SEL_GCTL), .be(req_be),
    .wdata(req_wdata), .q(gctl_q));
  rio_cfg_wreg #(.RST_VAL(32'h0), .WR_MASK(MASK_MREQ)) u_mreq (
    .clk(clk), .rst_n(rst_n), .we(wr && sel == SEL_MREQ), .be(req_be),
    .wdata(req_wdata), .q(mreq_q));

  rio_cfg_lock u_lock (
    .clk(clk), .rst_n(rst_n), .we(wr && sel == SEL_LOCK), .be(req_be[1:0]),
    .wdata(req_wdata[15:0]), .val(lock_val));

  always_comb begin
    unique case (sel)
      SEL_DEVID:   rd_mux = DEV_ID_CAR;
      SEL_DEVINFO: rd_mux = DEV_INFO_CAR;
      SEL_FEAT:    rd_mux = FEAT_VAL;
      SEL_BASEID:  rd_mux = baseid_q;
      SEL_LOCK:    rd_mux = {16'h0, lock_val};
      SEL_CTAG:    rd_mux = ctag_q;
      SEL_PHDR:    rd_mux = PORT_HDR;
      SEL_LTO:     rd_mux = lto_q;
      SEL_RTO:     rd_mux = rto_q;
      SEL_GCTL:    rd_mux = gctl_q;
      SEL_MREQ:    rd_mux = mreq_q;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write)
        rsp_rdata <= rd_mux;
    end
  end

  assign master_en     = gctl_q[MST_BIT];
  assign maint_dest_id = mreq_q[15:0];
endmodule

// File: rtl/rio_cfg_chk.sv
module rio_cfg_chk
  import rio_cfg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [CFG_AW-1:0] req_addr,
  input logic [CFG_BW-1:0] req_be,
  input logic [CFG_DW-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              master_en,
  input logic [15:0]       maint_dest_id,
  input logic [15:0]       lock_val
);
  logic lock_wr, gctl_wr, mreq_wr, rd_req;
  assign rd_req  = req_valid && !req_write;
  assign lock_wr = req_valid && req_write && req_addr[CFG_AW-1:2] == OFF_LOCK[CFG_AW-1:2]
                   && req_be[1:0] == 2'b11;
  assign gctl_wr = req_valid && req_write && req_addr[CFG_AW-1:2] == OFF_GCTL[CFG_AW-1:2];
  assign mreq_wr = req_valid && req_write && req_addr[CFG_AW-1:2] == OFF_MREQ[CFG_AW-1:2];

  p_rsp_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);
  p_no_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid);
  p_claim_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_wr && lock_val == LOCK_FREE) |=> lock_val == $past(req_wdata[15:0]));
  p_foreign_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_wr && lock_val != LOCK_FREE && req_wdata[15:0] != lock_val) |=> $stable(lock_val));
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_wr && lock_val != LOCK_FREE && req_wdata[15:0] == lock_val) |=> lock_val == LOCK_FREE);
  p_lock_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_wr |=> $stable(lock_val));
  p_mst_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(gctl_wr && req_be[3]) |=> $stable(master_en));
  p_dest_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mreq_wr && req_be[1:0] != 2'b00) |=> $stable(maint_dest_id));
endmodule

bind rio_cfg_regs rio_cfg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .master_en(master_en), .maint_dest_id(maint_dest_id),
  .lock_val(lock_val));

// File: tb/rio_cfg_regs_bench.sv
module rio_cfg_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        master_en;
  logic [15:0] maint_dest_id;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rio_cfg_regs u_rio_cfg_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .master_en(master_en), .maint_dest_id(maint_dest_id));

  // {write, addr, be, wdata, expected read data, requirement number}
  localparam int NV = 36;
  localparam logic [100:0] VEC [NV] = '{
    {1'b0, 24'h000068, 4'hF, 32'h0, 32'h0000FFFF, 8'd1},   // R1
    {1'b0, 24'h000060, 4'hF, 32'h0, 32'h00000001, 8'd1},   // R1
    {1'b0, 24'h00013C, 4'hF, 32'h0, 32'h00000000, 8'd11},  // R11
    {1'b0, 24'h000010, 4'hF, 32'h0, 32'hE0000019, 8'd3},   // R3
    {1'b1, 24'h000010, 4'hF, 32'hFFFFFFFF, 32'h0, 8'd3},
    {1'b0, 24'h000010, 4'hF, 32'h0, 32'hE0000019, 8'd3},   // R3
    {1'b1, 24'h000060, 4'hF, 32'h00AB0005, 32'h0, 8'd5},
    {1'b0, 24'h000060, 4'hF, 32'h0, 32'h00AB0005, 8'd5},   // R5
    {1'b1, 24'h00006C, 4'h5, 32'h11223344, 32'h0, 8'd5},
    {1'b0, 24'h00006C, 4'hF, 32'h0, 32'h00220044, 8'd5},   // R5
    {1'b1, 24'h00006C, 4'hA, 32'hAABBCCDD, 32'h0, 8'd5},
    {1'b0, 24'h00006C, 4'hF, 32'h0, 32'hAA22CC44, 8'd5},   // R5
    {1'b0, 24'h000120, 4'hF, 32'h0, 32'hFFFFFF00, 8'd13},  // R13
    {1'b1, 24'h000120, 4'hF, 32'h12345678, 32'h0, 8'd13},
    {1'b0, 24'h000120, 4'hF, 32'h0, 32'h12345600, 8'd13},  // R13
    {1'b1, 24'h000124, 4'h8, 32'h00000000, 32'h0, 8'd13},
    {1'b0, 24'h000124, 4'hF, 32'h0, 32'h00FFFF00, 8'd13},  // R13
    {1'b1, 24'h00013C, 4'hF, 32'hFFFFFFFF, 32'h0, 8'd11},
    {1'b0, 24'h00013C, 4'hF, 32'h0, 32'hE0000000, 8'd11},  // R11
    {1'b1, 24'h010100, 4'hF, 32'hDEADBEEF, 32'h0, 8'd12},
    {1'b0, 24'h010100, 4'hF, 32'h0, 32'h0000BEEF, 8'd12},  // R12
    {1'b1, 24'h000070, 4'hF, 32'h5A5A5A5A, 32'h0, 8'd4},
    {1'b0, 24'h000070, 4'hF, 32'h0, 32'h00000000, 8'd4},   // R4
    {1'b1, 24'h000068, 4'hF, 32'h0000FFFF, 32'h0, 8'd9},
    {1'b0, 24'h000068, 4'hF, 32'h0, 32'h0000FFFF, 8'd9},   // R9
    {1'b1, 24'h000068, 4'h1, 32'h00000042, 32'h0, 8'd10},
    {1'b0, 24'h000068, 4'hF, 32'h0, 32'h0000FFFF, 8'd10},  // R10
    {1'b1, 24'h000068, 4'hF, 32'hABCD0042, 32'h0, 8'd6},
    {1'b0, 24'h000068, 4'hF, 32'h0, 32'h00000042, 8'd6},   // R6, R10 upper zero
    {1'b1, 24'h000068, 4'hF, 32'h00000099, 32'h0, 8'd7},
    {1'b0, 24'h000068, 4'hF, 32'h0, 32'h00000042, 8'd7},   // R7
    {1'b1, 24'h000068, 4'hF, 32'h0000FFFF, 32'h0, 8'd7},
    {1'b0, 24'h000068, 4'hF, 32'h0, 32'h00000042, 8'd7},   // R7
    {1'b1, 24'h000068, 4'hF, 32'h00000042, 32'h0, 8'd8},
    {1'b0, 24'h000068, 4'hF, 32'h0, 32'h0000FFFF, 8'd8},   // R8
    {1'b1, 24'h000068, 4'hF, 32'h00000007, 32'h0, 8'd6}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [23:0] a, input logic [3:0] be,
                        input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 master_en", {31'b0, master_en}, 32'h0);
    check("R1 maint_dest_id", {16'b0, maint_dest_id}, 32'h0);
    check("R2 req_ready", {31'b0, req_ready}, 32'h1);
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][100], VEC[i][99:76], VEC[i][75:72], VEC[i][71:40]);
      if (VEC[i][100]) begin
        check($sformatf("R2 no response to write, vector %0d", i), {31'b0, rsp_valid}, 32'h0);
      end else begin
        check($sformatf("R2 read response, vector %0d", i), {31'b0, rsp_valid}, 32'h1);
        check($sformatf("R%0d vector %0d", VEC[i][7:0], i), rsp_rdata, VEC[i][39:8]);
      end
    end
    // R6: the last vector claimed the lock with 0x0007
    access(1'b0, 24'h000068, 4'hF, 32'h0);
    check("R6 reclaimed", rsp_rdata, 32'h00000007);
    // R11 / R12 outputs follow their words
    check("R11 master_en set", {31'b0, master_en}, 32'h1);
    check("R12 maint_dest_id", {16'b0, maint_dest_id}, 32'h0000BEEF);
    access(1'b1, 24'h00013C, 4'h8, 32'hBFFFFFFF);
    check("R11 master_en cleared by bit 30", {31'b0, master_en}, 32'h0);
    access(1'b0, 24'h00013C, 4'hF, 32'h0);
    check("R11 other control bits kept", rsp_rdata, 32'hA0000000);
    access(1'b1, 24'h010100, 4'h2, 32'h00001200);
    check("R12 byte-enabled dest id", {16'b0, maint_dest_id}, 32'h000012EF);
    // R4: a write to an empty offset must not land in a live register
    access(1'b1, 24'h000200, 4'hF, 32'hFFFFFFFF);
    access(1'b0, 24'h000200, 4'hF, 32'h0);
    check("R4 empty offset reads zero", rsp_rdata, 32'h0);
    access(1'b0, 24'h00006C, 4'hF, 32'h0);
    check("R4 component tag untouched", rsp_rdata, 32'hAA22CC44);
    // R2: a request held for two cycles gives back-to-back responses
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 24'h000000; req_be = 4'hF;
    @(negedge clk);
    check("R2 first response", {31'b0, rsp_valid}, 32'h1);
    req_addr = 24'h000100;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 back-to-back data", rsp_rdata, 32'h00000001);
    @(negedge clk);
    check("R2 idle after reads", {31'b0, rsp_valid}, 32'h0);
    // R1: a reset in mid-run restores every default
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 master_en after reset", {31'b0, master_en}, 32'h0);
    check("R1 dest id after reset", {16'b0, maint_dest_id}, 32'h0);
    access(1'b0, 24'h000068, 4'hF, 32'h0);
    check("R1 lock free after reset", rsp_rdata, 32'h0000FFFF);
    access(1'b0, 24'h000060, 4'hF, 32'h0);
    check("R1 base id after reset", rsp_rdata, 32'h00000001);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule